// File: doc/BRIEF.md
# Accumulator Unit With Decimal Correction

This block keeps an 8-bit accumulator together with a carry flag and a half-carry flag. It carries out the single-operand accumulator operations of a small processor core: clear, increment, decrement, rotate right or left through the carry, nibble swap and decimal correction. It also sets or clears the carry, and it evaluates the carry-conditional tests that tell the sequencer to skip the next instruction.

Each operation is presented as a 4-bit code together with a one-cycle valid strobe. A separate input records whether the last two-operand arithmetic step was a subtract or an add, which selects the decimal correction direction. The two-operand adder is outside this block. All outputs are registered, and every operation completes in the cycle it is accepted.

Top module: `acc_unit`

## Requirements
- R1: A synchronous active-high reset sets the accumulator, the carry, the half-carry and skip to 0. Reset takes priority over an operation presented in the same cycle.
- R2: The operation codes are 0 no-op, 1 clear, 2 increment, 3 decrement, 4 rotate right through carry, 5 rotate left through carry, 6 swap, 7 decimal correct, 8 set carry, 9 reset carry, 10 if-carry, 11 if-not-carry. Clear loads 0, increment adds 1 modulo 256, and decrement subtracts 1 modulo 256.
- R3: Clear, increment, decrement and swap leave the carry and half-carry unchanged.
- R4: Rotate right loads the old carry into bit 7, shifts the remaining bits down one place, and puts the old bit 0 into the carry. The half-carry is unchanged.
- R5: Rotate left loads the old carry into bit 0, shifts the remaining bits up one place, puts the old bit 7 into the carry, and puts the old bit 0 into the half-carry.
- R6: Swap exchanges accumulator bits 7..4 with bits 3..0.
- R7: Set carry drives both the carry and the half-carry to 1. Reset carry drives both to 0. The accumulator is not changed.
- R8: Decimal correct with the subtract input at 0 adds 6 when the half-carry is 1 or the low nibble exceeds 9. It adds 0x60 when the carry is 1 or the accumulator exceeds 0x99. Both tests use the value before correction, and the sum wraps modulo 256. The carry becomes 1 exactly when the 0x60 term was applied, and the half-carry is unchanged.
- R9: Decimal correct with the subtract input at 1 subtracts 6 when the half-carry is 0 and subtracts 0x60 when the carry is 0, modulo 256. Both flags are unchanged.
- R10: If-carry drives skip to 1 in the cycle after it is accepted when the carry is 0. If-not-carry does the same when the carry is 1. In all other cases skip is 0 in that cycle. Neither test changes the accumulator or the flags.
- R11: With valid low, with code 0, or with codes 12 to 15, the accumulator and the flags hold their values and skip is 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation strobe, one operation per cycle |
| op_code | input | 4 | Operation code |
| prev_sub | input | 1 | 1 when the last two-operand arithmetic step was a subtract |
| acc_q | output | 8 | Accumulator |
| carry_q | output | 1 | Carry flag |
| hcarry_q | output | 1 | Half-carry flag |
| skip_q | output | 1 | Skip-next-instruction pulse |

## Verification
Two functions share a single cycle here. A flag-writing operation, such as set carry, reset carry or a rotate, can be followed directly by a carry test. The test must then judge the flag value that the first operation has just registered, not the value from before it. The bench issues reset carry immediately followed by if-carry, and set carry immediately followed by if-not-carry, with no idle cycle between them, and expects a skip pulse in both cases. Decimal correction is a second case of this kind: the low and high corrections can both apply in one step, and the carry must be updated in the same step. Table entries where both corrections fire are judged on the accumulator and the carry together.

// File: rtl/acc_pkg.sv
package acc_pkg;
  typedef enum logic [3:0] {
    OP_NOP  = 4'd0,
    OP_CLR  = 4'd1,
    OP_INC  = 4'd2,
    OP_DEC  = 4'd3,
    OP_RRC  = 4'd4,
    OP_RLC  = 4'd5,
    OP_SWAP = 4'd6,
    OP_DCOR = 4'd7,
    OP_SC   = 4'd8,
    OP_RC   = 4'd9,
    OP_IFC  = 4'd10,
    OP_IFNC = 4'd11
  } acc_op_e;
endpackage

// File: rtl/acc_shift.sv
module acc_shift
  import acc_pkg::*;
#(
  parameter int ACC_W = 8
) (
  input  acc_op_e          op,
  input  logic [ACC_W-1:0] a,
  input  logic             c,
  input  logic             h,
  output logic [ACC_W-1:0] a_n,
  output logic             c_n,
  output logic             h_n
);
  localparam int HALF = ACC_W / 2;

  always_comb begin
    a_n = a;
    c_n = c;
    h_n = h;
    unique case (op)
      OP_RRC: begin
        a_n = {c, a[ACC_W-1:1]};
        c_n = a[0];
      end
      OP_RLC: begin
        a_n = {a[ACC_W-2:0], c};
        c_n = a[ACC_W-1];
        h_n = a[0];
      end
      OP_SWAP: a_n = {a[HALF-1:0], a[ACC_W-1:HALF]};
      default: ;
    endcase
  end
endmodule

// File: rtl/acc_bcd_adj.sv
module acc_bcd_adj #(
  parameter int ACC_W = 8
) (
  input  logic [ACC_W-1:0] a,
  input  logic             c,
  input  logic             h,
  input  logic             sub,
  output logic [ACC_W-1:0] a_n,
  output logic             c_n
);
  localparam int NIB_W = ACC_W / 2;
  localparam logic [NIB_W-1:0] SIX  = NIB_W'(6);
  localparam logic [NIB_W-1:0] NINE = NIB_W'(9);
  localparam logic [NIB_W-1:0] ZERO = '0;

  logic [NIB_W-1:0] lo, hi;
  logic lo_big, hi_big, lo_fix, hi_fix;
  logic [ACC_W-1:0] corr_add, corr_sub;

  always_comb begin
    lo       = a[NIB_W-1:0];
    hi       = a[ACC_W-1:NIB_W];
    lo_big   = lo > NINE;
    hi_big   = (hi > NINE) || ((hi == NINE) && lo_big);
    lo_fix   = h | lo_big;
    hi_fix   = c | hi_big;
    corr_add = {hi_fix ? SIX : ZERO, lo_fix ? SIX : ZERO};
    corr_sub = {c ? ZERO : SIX, h ? ZERO : SIX};
    a_n      = sub ? (a - corr_sub) : (a + corr_add);
    c_n      = sub ? c : hi_fix;
  end
endmodule

// File: rtl/acc_cond_test.sv
module acc_cond_test
  import acc_pkg::*;
(
  input  logic    op_valid,
  input  acc_op_e op,
  input  logic    c,
  output logic    skip_n
);
  always_comb begin
    skip_n = 1'b0;
    if (op_valid) begin
      if (op == OP_IFC)  skip_n = ~c;
      if (op == OP_IFNC) skip_n = c;
    end
  end
endmodule

// File: rtl/acc_unit.sv
module acc_unit
  import acc_pkg::*;
#(
  parameter int ACC_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             op_valid,
  input  logic [3:0]       op_code,
  input  logic             prev_sub,
  output logic [ACC_W-1:0] acc_q,
  output logic             carry_q,
  output logic             hcarry_q,
  output logic             skip_q
);
  localparam logic [ACC_W-1:0] ONE = ACC_W'(1);

  acc_op_e          op;
  logic [ACC_W-1:0] sh_a, bcd_a;
  logic             sh_c, sh_h, bcd_c, skip_n;

  assign op = acc_op_e'(op_code);

  acc_shift #(.ACC_W(ACC_W)) u_shift (
    .op(op), .a(acc_q), .c(carry_q), .h(hcarry_q),
    .a_n(sh_a), .c_n(sh_c), .h_n(sh_h)
  );

  acc_bcd_adj #(.ACC_W(ACC_W)) u_bcd (
    .a(acc_q), .c(carry_q), .h(hcarry_q), .sub(prev_sub),
    .a_n(bcd_a), .c_n(bcd_c)
  );

  acc_cond_test u_cond (
    .op_valid(op_valid), .op(op), .c(carry_q), .skip_n(skip_n)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q    <= '0;
      carry_q  <= 1'b0;
      hcarry_q <= 1'b0;
      skip_q   <= 1'b0;
    end else begin
      skip_q <= skip_n;
      if (op_valid) begin
        case (op)
          OP_CLR: acc_q <= '0;
          OP_INC: acc_q <= acc_q + ONE;
          OP_DEC: acc_q <= acc_q - ONE;
          OP_RRC, OP_RLC, OP_SWAP: begin
            acc_q    <= sh_a;
            carry_q  <= sh_c;
            hcarry_q <= sh_h;
          end
          OP_DCOR: begin
            acc_q   <= bcd_a;
            carry_q <= bcd_c;
          end
          OP_SC: begin
            carry_q  <= 1'b1;
            hcarry_q <= 1'b1;
          end
          OP_RC: begin
            carry_q  <= 1'b0;
            hcarry_q <= 1'b0;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/acc_unit_chk.sv
module acc_unit_chk #(
  parameter int ACC_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             op_valid,
  input logic [3:0]       op_code,
  input logic             prev_sub,
  input logic [ACC_W-1:0] acc_q,
  input logic             carry_q,
  input logic             hcarry_q,
  input logic             skip_q
);
  localparam int HALF = ACC_W / 2;

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (acc_q == '0) && !carry_q && !hcarry_q && !skip_q); // R1

  AST_CLR_ZERO: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code == 4'd1) |=> acc_q == '0); // R2

  AST_COUNT_KEEPS_FLAGS: assert property (@(posedge clk) disable iff (rst)
    (op_valid && (op_code == 4'd1 || op_code == 4'd2 || op_code == 4'd3 || op_code == 4'd6))
    |=> $stable(carry_q) && $stable(hcarry_q)); // R3

  AST_RRC_CARRY_OUT: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code == 4'd4)
    |=> carry_q == $past(acc_q[0]) && acc_q[ACC_W-1] == $past(carry_q)); // R4

  AST_RLC_FLAGS: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code == 4'd5)
    |=> carry_q == $past(acc_q[ACC_W-1]) && hcarry_q == $past(acc_q[0])); // R5

  AST_SWAP_NIBBLES: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code == 4'd6)
    |=> acc_q == {$past(acc_q[HALF-1:0]), $past(acc_q[ACC_W-1:HALF])}); // R6

  AST_SC_BOTH: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code == 4'd8) |=> carry_q && hcarry_q && $stable(acc_q)); // R7

  AST_RC_BOTH: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code == 4'd9) |=> !carry_q && !hcarry_q && $stable(acc_q)); // R7

  AST_DCOR_SUB_FLAGS: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code == 4'd7 && prev_sub)
    |=> $stable(carry_q) && $stable(hcarry_q)); // R9

  AST_SKIP_SOURCE: assert property (@(posedge clk) disable iff (rst)
    skip_q |-> $past(op_valid) && ($past(op_code) == 4'd10 || $past(op_code) == 4'd11)); // R10

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!op_valid || op_code == 4'd0 || op_code >= 4'd12)
    |=> $stable(acc_q) && $stable(carry_q) && $stable(hcarry_q) && !skip_q); // R11
endmodule

bind acc_unit acc_unit_chk #(.ACC_W(ACC_W)) u_chk (
  .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
  .prev_sub(prev_sub), .acc_q(acc_q), .carry_q(carry_q),
  .hcarry_q(hcarry_q), .skip_q(skip_q)
);

// File: tb/acc_unit_tb.sv
module acc_unit_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       op_valid = 1'b0;
  logic [3:0] op_code = 4'd0;
  logic       prev_sub = 1'b0;
  logic [7:0] acc_q;
  logic       carry_q, hcarry_q, skip_q;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  acc_unit #(.ACC_W(8)) u_dut (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
    .prev_sub(prev_sub), .acc_q(acc_q), .carry_q(carry_q),
    .hcarry_q(hcarry_q), .skip_q(skip_q)
  );

  // {a, c, h, sub, exp_a, exp_c, exp_h}
  localparam logic [20:0] VEC [16] = '{
    {8'h00, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0},
    {8'h0A, 1'b0, 1'b0, 1'b0, 8'h10, 1'b0, 1'b0},
    {8'h12, 1'b0, 1'b1, 1'b0, 8'h18, 1'b0, 1'b1},
    {8'hA0, 1'b0, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0},
    {8'h9A, 1'b0, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0},
    {8'h99, 1'b0, 1'b0, 1'b0, 8'h99, 1'b0, 1'b0},
    {8'h15, 1'b1, 1'b0, 1'b0, 8'h75, 1'b1, 1'b0},
    {8'hFF, 1'b0, 1'b0, 1'b0, 8'h65, 1'b1, 1'b0},
    {8'h3C, 1'b1, 1'b1, 1'b0, 8'hA2, 1'b1, 1'b1},
    {8'h45, 1'b0, 1'b0, 1'b0, 8'h45, 1'b0, 1'b0},
    {8'h45, 1'b1, 1'b1, 1'b1, 8'h45, 1'b1, 1'b1},
    {8'h4F, 1'b1, 1'b0, 1'b1, 8'h49, 1'b1, 1'b0},
    {8'h93, 1'b0, 1'b1, 1'b1, 8'h33, 1'b0, 1'b1},
    {8'h00, 1'b0, 1'b0, 1'b1, 8'h9A, 1'b0, 1'b0},
    {8'h78, 1'b0, 1'b0, 1'b1, 8'h12, 1'b0, 1'b0},
    {8'hE5, 1'b0, 1'b1, 1'b1, 8'h85, 1'b0, 1'b1}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic check_state(input string req, input logic [7:0] a, input logic c, input logic h);
    check(req, {24'd0, acc_q}, {24'd0, a});
    check(req, {31'd0, carry_q}, {31'd0, c});
    check(req, {31'd0, hcarry_q}, {31'd0, h});
  endtask

  task automatic do_op(input logic [3:0] code);
    @(negedge clk);
    op_valid = 1'b1;
    op_code  = code;
    @(negedge clk);
    op_valid = 1'b0;
    op_code  = 4'd0;
  endtask

  task automatic do_pair(input logic [3:0] first, input logic [3:0] second);
    @(negedge clk);
    op_valid = 1'b1;
    op_code  = first;
    @(negedge clk);
    op_code  = second;
    @(negedge clk);
    op_valid = 1'b0;
    op_code  = 4'd0;
  endtask

  // Reach accumulator v with carry c and half-carry h using only the unit's own operations.
  task automatic set_state(input logic [7:0] v, input logic c, input logic h);
    do_op(h ? 4'd8 : 4'd9);
    do_op(4'd1);
    if (c != h) begin
      do_op(4'd1);
      if (c) do_op(4'd2);
      do_op(4'd4);
    end
    do_op(4'd1);
    for (int i = 0; i < int'(v); i++) do_op(4'd2);
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check_state("R1 reset", 8'h00, 1'b0, 1'b0);
    check("R1 reset skip", {31'd0, skip_q}, 32'd0);

    // R8 / R9 table walk
    for (int k = 0; k < 16; k++) begin
      set_state(VEC[k][20:13], VEC[k][12], VEC[k][11]);
      prev_sub = VEC[k][10];
      check_state("R8/R9 setup", VEC[k][20:13], VEC[k][12], VEC[k][11]);
      do_op(4'd7);
      check_state(VEC[k][10] ? "R9 dcor sub" : "R8 dcor add", VEC[k][9:2], VEC[k][1], VEC[k][0]);
    end
    prev_sub = 1'b0;

    // R2 R3 clear/increment/decrement wrap, flags held
    set_state(8'hFF, 1'b1, 1'b0);
    do_op(4'd2);
    check_state("R2 R3 inc wrap", 8'h00, 1'b1, 1'b0);
    do_op(4'd3);
    check_state("R2 R3 dec wrap", 8'hFF, 1'b1, 1'b0);
    do_op(4'd1);
    check_state("R2 R3 clear", 8'h00, 1'b1, 1'b0);

    // R4 rotate right
    set_state(8'h81, 1'b1, 1'b0);
    do_op(4'd4);
    check_state("R4 rrc", 8'hC0, 1'b1, 1'b0);
    do_op(4'd4);
    check_state("R4 rrc second", 8'hE0, 1'b0, 1'b0);

    // R5 rotate left with half-carry
    set_state(8'h81, 1'b0, 1'b0);
    do_op(4'd5);
    check_state("R5 rlc", 8'h02, 1'b1, 1'b1);
    do_op(4'd5);
    check_state("R5 rlc second", 8'h05, 1'b0, 1'b0);

    // R6 swap
    set_state(8'h3C, 1'b0, 1'b1);
    do_op(4'd6);
    check_state("R6 R3 swap", 8'hC3, 1'b0, 1'b1);

    // R7 set/reset carry
    do_op(4'd8);
    check_state("R7 sc", 8'hC3, 1'b1, 1'b1);
    do_op(4'd9);
    check_state("R7 rc", 8'hC3, 1'b0, 1'b0);

    // R10 carry tests
    set_state(8'h21, 1'b1, 1'b0);
    do_op(4'd10);
    check("R10 ifc with carry set", {31'd0, skip_q}, 32'd0);
    do_op(4'd11);
    check("R10 ifnc with carry set", {31'd0, skip_q}, 32'd1);
    check_state("R10 state held", 8'h21, 1'b1, 1'b0);
    @(negedge clk);
    check("R10 skip one cycle", {31'd0, skip_q}, 32'd0);

    // R10 back-to-back flag write then test
    do_pair(4'd9, 4'd10);
    check("R10 rc then ifc", {31'd0, skip_q}, 32'd1);
    do_pair(4'd8, 4'd11);
    check("R10 sc then ifnc", {31'd0, skip_q}, 32'd1);
    do_pair(4'd9, 4'd11);
    check("R10 rc then ifnc", {31'd0, skip_q}, 32'd0);

    // R11 no-op, unused codes, idle
    set_state(8'h5A, 1'b0, 1'b1);
    do_op(4'd0);
    check_state("R11 nop", 8'h5A, 1'b0, 1'b1);
    do_op(4'd13);
    check_state("R11 unused code", 8'h5A, 1'b0, 1'b1);
    check("R11 unused skip", {31'd0, skip_q}, 32'd0);
    @(negedge clk);
    op_code = 4'd1;
    @(negedge clk);
    op_code = 4'd0;
    check_state("R11 valid low", 8'h5A, 1'b0, 1'b1);

    // R1 reset priority over a pending operation
    @(negedge clk);
    rst = 1'b1;
    op_valid = 1'b1;
    op_code = 4'd8;
    @(negedge clk);
    op_valid = 1'b0;
    op_code = 4'd0;
    rst = 1'b0;
    check_state("R1 reset priority", 8'h00, 1'b0, 1'b0);

    done = 1'b1;
    finish_run();
  end
endmodule